// File: doc/BRIEF.md
# Timer Channel Up-Counter with Selectable Source, Edge and Clear

This block is the counting core of one channel of a general-purpose timer. It holds a 16-bit up-counter and an 8-bit control register. The control register picks where count pulses come from, which edge of that source advances the counter, and which event resets the counter to zero. A free-running divider supplies six prescaled rates of the system clock. An external clock pin is synchronised and edge-detected. A cascade input lets a neighbouring channel's overflow drive this counter.

All counting is done in the system clock domain with single-cycle enables, and no derived clocks are used. Compare and capture comparators sit outside the block. Their hits arrive as four event inputs, named A to D. A fifth input carries the synchronous-clear strobe from another channel. Registers C and D can be flagged as buffers, and while flagged they cannot clear the counter. Software writes the control register and the counter over a simple write strobe, and reads both directly.

Top module: `tmr_chan_counter`

## Requirements
- R1: After reset `cnt_q`, `ctl_q` and `ovf_pulse` are all 0. This selects counting on every system cycle with clearing off.
- R2: The control register holds the clear field in bits [7:5], the edge field in bits [4:3] and the source field in bits [2:0]. It is loaded from `bus_wdata[7:0]` on `bus_wr_ctl` and is readable on `ctl_q` from the next cycle.
- R3: Source code 000 advances the counter on every cycle, and the edge field has no effect in this mode.
- R4: Source codes 001, 010, 011, 110, 101 and 111 select internal divide ratios N of 4, 16, 64, 256, 1024 and 4096. Let t be the number of cycles since reset was released, with t = 0 in the first cycle. The rising-edge enable occurs in cycles where t mod N = N/2-1, and the falling-edge enable in cycles where t mod N = N-1.
- R5: The edge field selects the counting edge. Code 00 counts rising edges, 01 counts falling edges, and 10 or 11 count both, which doubles the rate.
- R6: Source code 100 counts edges of `ext_clk_a` after a two-flop synchroniser. A pin edge set up before clock edge k advances the counter at clock edge k+2.
- R7: While `casc_en` is 1, the counter advances on every cycle in which `casc_tick` is 1. The source field and the edge field are then ignored.
- R8: The clear field selects the clearing event as follows. 001 selects `evt_a`, 010 selects `evt_b`, 101 selects `evt_c` and 110 selects `evt_d`. 011 and 111 select `sync_clr_in`. 000 and 100 never clear. A selected event sets the counter to 0 at the next edge.
- R9: When `buf_c_mode` or `buf_d_mode` is 1, the event of that register does not clear the counter.
- R10: `sync_clr_in` clears the counter only while `sync_en` is 1.
- R11: In any one cycle a counter write from `bus_wdata` takes priority over a clear, and a clear takes priority over a count.
- R12: A count from 0xFFFF wraps the counter to 0 and raises `ovf_pulse` for exactly one cycle. A clear or a write does not raise `ovf_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_ctl | input | 1 | Write strobe for the control register |
| bus_wr_cnt | input | 1 | Write strobe for the counter |
| bus_wdata | input | 16 | Write data |
| ext_clk_a | input | 1 | Asynchronous external count pin |
| casc_en | input | 1 | Selects the cascade input as the count source |
| casc_tick | input | 1 | Count pulse from the neighbouring channel |
| evt_a | input | 1 | Match/capture event of register A |
| evt_b | input | 1 | Match/capture event of register B |
| evt_c | input | 1 | Match/capture event of register C |
| evt_d | input | 1 | Match/capture event of register D |
| buf_c_mode | input | 1 | Register C is acting as a buffer |
| buf_d_mode | input | 1 | Register D is acting as a buffer |
| sync_en | input | 1 | Synchronous operation enabled for this channel |
| sync_clr_in | input | 1 | Synchronous-clear strobe from another channel |
| ctl_q | output | 8 | Control register read value |
| cnt_q | output | 16 | Counter read value |
| ovf_pulse | output | 1 | One-cycle overflow flag |

## Verification
If the divider phase is wrong, the count times drift against the t-based schedule. For the slow ratios this shows only at the first enable, which can be up to 4096 cycles late or early. For that reason each ratio is run past at least one full period. An error in the synchroniser depth, or in the edge detect, moves external counts by whole cycles, and the cycle-exact reference model flags this on the first pin edge. A wrong clear decode or a wrong priority leaves a nonzero counter, or a counter of zero where none was expected, one cycle after the event. A faulty wrap shows as a missing or doubled `ovf_pulse` at the 0xFFFF boundary.

// File: rtl/tmr_pkg.sv
// Shared widths and control-field encodings for the timer channel counter.
package tmr_pkg;
    localparam int CNT_W     = 16;   // counter width
    localparam int CTL_W     = 8;    // control register width
    localparam int PSC_DIV_W = 12;   // divider width, must reach the slowest ratio

    // Source field codes (bits [2:0])
    localparam logic [2:0] SRC_DIV1   = 3'b000;
    localparam logic [2:0] SRC_EXTPIN = 3'b100;

    // Clear field codes (bits [7:5])
    localparam logic [2:0] CLR_A = 3'b001;
    localparam logic [2:0] CLR_B = 3'b010;
    localparam logic [2:0] CLR_C = 3'b101;
    localparam logic [2:0] CLR_D = 3'b110;

    // Edge field (bits [4:3])
    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_ALSO = 2'b11
    } edge_mode_e;

    // log2 of the internal ratio for a source code; 0 means "not a divided source"
    function automatic int unsigned psc_log2(input logic [2:0] code);
        case (code)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 6;
            3'b110:  return 8;
            3'b101:  return 10;
            3'b111:  return 12;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
// Free-running divider that turns the selected internal ratio and edge mode
// into a one-cycle count enable. Assumes DIV_W is at least the largest log2
// ratio in tmr_pkg. In ratio 1 the enable is always high and the edge is ignored.
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int DIV_W = PSC_DIV_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] psc_sel,
    input  logic [1:0] edge_sel,
    output logic       int_tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] ph_mask;
    logic [DIV_W-1:0] phase;
    logic             rise_en;
    logic             fall_en;
    int unsigned      lg;

    // Divider advances every cycle, restarting at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Phase decode: the half-period point models the rising edge, the wrap point the falling edge.
    always_comb begin
        lg      = psc_log2(psc_sel);
        ph_mask = {DIV_W{1'b1}} >> (DIV_W - int'(lg));
        phase   = div_q & ph_mask;
        rise_en = (phase == (ph_mask >> 1));
        fall_en = (phase == ph_mask);
        if (lg == 0) begin
            int_tick = 1'b1;
        end else begin
            case (edge_mode_e'(edge_sel))
                EDGE_RISE: int_tick = rise_en;
                EDGE_FALL: int_tick = fall_en;
                default:   int_tick = rise_en | fall_en;
            endcase
        end
    end

    // R4: the divider steps by exactly one per cycle out of reset
    a_r4_div_steps: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> div_q == $past(div_q) + 1'b1);
endmodule

// File: rtl/tmr_ext_edge.sv
// Two-flop synchroniser and edge detector for the asynchronous count pin.
// Produces one-cycle rise and fall strobes two clocks after the pin settles.
module tmr_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, s3_q;

    // Synchronise the pin and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Edge strobes from the synchronised level.
    always_comb begin
        rise = s2_q & ~s3_q;
        fall = ~s2_q & s3_q;
    end

    // R6: each pin edge yields a strobe lasting a single cycle
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tmr_clr_sel.sv
// Clear-source selection. Buffer-mode registers never clear, and the
// cross-channel strobe only clears while synchronous operation is enabled.
module tmr_clr_sel
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clr_sel,
    input  logic       evt_a,
    input  logic       evt_b,
    input  logic       evt_c,
    input  logic       evt_d,
    input  logic       buf_c_mode,
    input  logic       buf_d_mode,
    input  logic       sync_en,
    input  logic       sync_clr_in,
    output logic       clr_hit
);
    // Decode the clear field into the one qualifying event.
    always_comb begin
        if (clr_sel[1:0] == 2'b11) begin
            clr_hit = sync_en & sync_clr_in;
        end else begin
            case (clr_sel)
                CLR_A:   clr_hit = evt_a;
                CLR_B:   clr_hit = evt_b;
                CLR_C:   clr_hit = evt_c & ~buf_c_mode;
                CLR_D:   clr_hit = evt_d & ~buf_d_mode;
                default: clr_hit = 1'b0;
            endcase
        end
    end

    // R9: a buffer register never produces a clear
    a_r9_buf_c_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_c_mode && clr_sel == CLR_C) |-> !clr_hit);
    a_r9_buf_d_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_d_mode && clr_sel == CLR_D) |-> !clr_hit);
    // R10: no cross-channel clear without synchronous operation
    a_r10_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && clr_sel[1:0] == 2'b11) |-> !clr_hit);
endmodule

// File: rtl/tmr_chan_counter.sv
// One timer channel counter: control register, source/edge selection,
// clear selection and the 16-bit up-counter with overflow strobe.
// Assumes event inputs are synchronous single-cycle pulses; the pin is asynchronous.
module tmr_chan_counter
    import tmr_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int DIV_W = PSC_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_ctl,
    input  logic             bus_wr_cnt,
    input  logic [W-1:0]     bus_wdata,
    input  logic             ext_clk_a,
    input  logic             casc_en,
    input  logic             casc_tick,
    input  logic             evt_a,
    input  logic             evt_b,
    input  logic             evt_c,
    input  logic             evt_d,
    input  logic             buf_c_mode,
    input  logic             buf_d_mode,
    input  logic             sync_en,
    input  logic             sync_clr_in,
    output logic [CTL_W-1:0] ctl_q,
    output logic [W-1:0]     cnt_q,
    output logic             ovf_pulse
);
    logic [CTL_W-1:0] ctl_r;
    logic [W-1:0]     cnt_r;
    logic             ovf_r;
    logic             int_tick, ext_rise, ext_fall, ext_tick;
    logic             cnt_en, clr_hit;
    logic [2:0]       src_f, clr_f;
    logic [1:0]       edge_f;

    assign src_f  = ctl_r[2:0];
    assign edge_f = ctl_r[4:3];
    assign clr_f  = ctl_r[7:5];

    tmr_prescale #(.DIV_W(DIV_W)) i_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .psc_sel  (src_f),
        .edge_sel (edge_f),
        .int_tick (int_tick)
    );

    tmr_ext_edge i_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk_a),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    tmr_clr_sel i_clr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_sel     (clr_f),
        .evt_a       (evt_a),
        .evt_b       (evt_b),
        .evt_c       (evt_c),
        .evt_d       (evt_d),
        .buf_c_mode  (buf_c_mode),
        .buf_d_mode  (buf_d_mode),
        .sync_en     (sync_en),
        .sync_clr_in (sync_clr_in),
        .clr_hit     (clr_hit)
    );

    // Pick the external edge named by the edge field.
    always_comb begin
        case (edge_mode_e'(edge_f))
            EDGE_RISE: ext_tick = ext_rise;
            EDGE_FALL: ext_tick = ext_fall;
            default:   ext_tick = ext_rise | ext_fall;
        endcase
    end

    // Final count enable: cascade overrides, then pin, then internal divider.
    always_comb begin
        if (casc_en)                  cnt_en = casc_tick;
        else if (src_f == SRC_EXTPIN) cnt_en = ext_tick;
        else                          cnt_en = int_tick;
    end

    // Control register load.
    always_ff @(posedge clk) begin
        if (!rst_n)          ctl_r <= '0;
        else if (bus_wr_ctl) ctl_r <= bus_wdata[CTL_W-1:0];
    end

    // Counter update with write > clear > count priority and overflow strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r <= '0;
            ovf_r <= 1'b0;
        end else if (bus_wr_cnt) begin
            cnt_r <= bus_wdata;
            ovf_r <= 1'b0;
        end else if (clr_hit) begin
            cnt_r <= '0;
            ovf_r <= 1'b0;
        end else if (cnt_en) begin
            cnt_r <= cnt_r + 1'b1;
            ovf_r <= &cnt_r;
        end else begin
            ovf_r <= 1'b0;
        end
    end

    assign ctl_q     = ctl_r;
    assign cnt_q     = cnt_r;
    assign ovf_pulse = ovf_r;

    // R11: a counter write lands regardless of clear or count
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_cnt |=> cnt_q == $past(bus_wdata));
    // R8: a selected clear zeroes the counter without overflow
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !bus_wr_cnt) |=> (cnt_q == '0 && !ovf_pulse));
    // R12: overflow only accompanies a wrapped counter
    a_r12_ovf_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> cnt_q == '0);
    // R12: overflow lasts one cycle
    a_r12_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);
    // R3: without write or clear the counter holds or steps by one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_cnt && !clr_hit) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
    // R2: control register reflects the written byte
    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_ctl |=> ctl_q == $past(bus_wdata[CTL_W-1:0]));
endmodule

// File: tb/test_tmr_chan_counter.sv
// Self-checking bench: behavioural reference model stepped once per clock.
module test_tmr_chan_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_ctl = 1'b0, bus_wr_cnt = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        ext_clk_a = 1'b0, casc_en = 1'b0, casc_tick = 1'b0;
    logic        evt_a = 1'b0, evt_b = 1'b0, evt_c = 1'b0, evt_d = 1'b0;
    logic        buf_c_mode = 1'b0, buf_d_mode = 1'b0;
    logic        sync_en = 1'b0, sync_clr_in = 1'b0;
    logic [7:0]  ctl_q;
    logic [15:0] cnt_q;
    logic        ovf_pulse;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // reference model state
    int          m_t;
    logic [15:0] m_cnt;
    logic        m_ovf;
    logic [7:0]  m_ctl;
    logic        m_p1, m_p2, m_p3;

    tmr_chan_counter i_tmr_chan_counter (.*);

    always #10 clk = ~clk;   // 50 MHz

    task automatic model_reset();
        m_t = 0; m_cnt = '0; m_ovf = 1'b0; m_ctl = '0;
        m_p1 = 1'b0; m_p2 = 1'b0; m_p3 = 1'b0;
    endtask

    // One cycle of the reference behaviour from the current inputs.
    task automatic model_step();
        logic en, clr, r, f;
        int   n, ph;
        case (m_ctl[2:0])
            3'b001: n = 4;    3'b010: n = 16;   3'b011: n = 64;
            3'b110: n = 256;  3'b101: n = 1024; 3'b111: n = 4096;
            default: n = 1;
        endcase
        if (m_ctl[2:0] == 3'b100) begin
            r = m_p2 && !m_p3; f = !m_p2 && m_p3;
        end else begin
            ph = m_t % n;
            r = (ph == n / 2 - 1); f = (ph == n - 1);
        end
        if (m_ctl[4])        en = r || f;
        else if (m_ctl[3])   en = f;
        else                 en = r;
        if (n == 1 && m_ctl[2:0] != 3'b100) en = 1'b1;
        if (casc_en) en = casc_tick;
        case (m_ctl[7:5])
            3'b001: clr = evt_a;
            3'b010: clr = evt_b;
            3'b101: clr = evt_c && !buf_c_mode;
            3'b110: clr = evt_d && !buf_d_mode;
            3'b011, 3'b111: clr = sync_clr_in && sync_en;
            default: clr = 1'b0;
        endcase
        if (bus_wr_cnt)      begin m_cnt = bus_wdata; m_ovf = 1'b0; end
        else if (clr)        begin m_cnt = '0; m_ovf = 1'b0; end
        else if (en)         begin m_ovf = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 16'd1; end
        else                 m_ovf = 1'b0;
        if (bus_wr_ctl) m_ctl = bus_wdata[7:0];
        m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_clk_a;
        m_t = (m_t + 1) % 4096;
    endtask

    task automatic compare();
        checks++;
        if (cnt_q !== m_cnt || ovf_pulse !== m_ovf || ctl_q !== m_ctl) begin
            errors++;
            $display("FAIL %s t=%0t: cnt=%h ovf=%b ctl=%h expected cnt=%h ovf=%b ctl=%h",
                     cur_req, $time, cnt_q, ovf_pulse, ctl_q, m_cnt, m_ovf, m_ctl);
        end
    endtask

    // Inputs are set at a negedge; model and design step on the next posedge.
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_ctl(input logic [7:0] v);
        bus_wr_ctl = 1'b1; bus_wdata = {8'h00, v};
        tick();
        bus_wr_ctl = 1'b0;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        bus_wr_cnt = 1'b1; bus_wdata = v;
        tick();
        bus_wr_cnt = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R3: every-cycle counting, edge field has no effect
        cur_req = "R3"; run(20);
        set_ctl(8'b000_01_000); run(20);
        set_ctl(8'b000_11_000); run(20);
        // R2: control readback of arbitrary pattern
        cur_req = "R2"; set_ctl(8'b010_10_001); set_ctl(8'h00);
        // R4 / R5: internal ratios and edges
        cur_req = "R4"; set_ctl(8'b000_00_001); run(40);
        cur_req = "R5"; set_ctl(8'b000_01_001); run(40);
        set_ctl(8'b000_10_001); run(40);
        cur_req = "R4"; set_ctl(8'b000_11_010); run(70);
        set_ctl(8'b000_00_011); run(200);
        set_ctl(8'b000_01_110); run(600);
        cur_req = "R5"; set_ctl(8'b000_10_101); run(2100);
        cur_req = "R4"; set_ctl(8'b000_00_111); run(4200);
        // R6: external pin, each edge mode, varied periods
        cur_req = "R6";
        for (int m = 0; m < 3; m++) begin
            set_ctl({3'b000, m[1:0], 3'b100});
            for (int k = 0; k < 30; k++) begin
                ext_clk_a = ~ext_clk_a;
                run(1 + (k % 4));
            end
        end
        for (int k = 0; k < 200; k++) begin
            ext_clk_a = 1'($urandom);
            tick();
        end
        ext_clk_a = 1'b0;
        // R7: cascade overrides source and edge fields
        cur_req = "R7"; set_ctl(8'b000_10_011); casc_en = 1'b1;
        for (int k = 0; k < 150; k++) begin
            casc_tick = 1'($urandom);
            tick();
        end
        casc_tick = 1'b0; casc_en = 1'b0;
        // R8: each clear code against each event
        cur_req = "R8";
        for (int c = 0; c < 8; c++) begin
            set_ctl({c[2:0], 5'b00000});
            sync_en = 1'b1;
            for (int e = 0; e < 5; e++) begin
                run(3);
                evt_a = (e == 0); evt_b = (e == 1); evt_c = (e == 2);
                evt_d = (e == 3); sync_clr_in = (e == 4);
                tick();
                {evt_a, evt_b, evt_c, evt_d, sync_clr_in} = '0;
            end
        end
        // R9: buffer flags suppress C and D clears
        cur_req = "R9"; buf_c_mode = 1'b1; buf_d_mode = 1'b1;
        set_ctl(8'b101_00_000); run(4); evt_c = 1'b1; tick(); evt_c = 1'b0; run(2);
        set_ctl(8'b110_00_000); run(4); evt_d = 1'b1; tick(); evt_d = 1'b0; run(2);
        buf_c_mode = 1'b0; buf_d_mode = 1'b0;
        // R10: synchronous clear gated by enable
        cur_req = "R10"; set_ctl(8'b011_00_000); sync_en = 1'b0;
        run(3); sync_clr_in = 1'b1; tick(); sync_clr_in = 1'b0; run(2);
        sync_en = 1'b1; sync_clr_in = 1'b1; tick(); sync_clr_in = 1'b0; run(2);
        // R11: write beats clear, clear beats count
        cur_req = "R11"; set_ctl(8'b001_00_000);
        evt_a = 1'b1; bus_wr_cnt = 1'b1; bus_wdata = 16'h1234; tick();
        bus_wr_cnt = 1'b0; tick(); evt_a = 1'b0; run(3);
        // R12: wrap and overflow, including clear at the boundary
        cur_req = "R12"; set_cnt(16'hFFFD); run(6);
        set_cnt(16'hFFFF); evt_a = 1'b1; tick(); evt_a = 1'b0; run(2);
        set_ctl(8'b000_00_001); set_cnt(16'hFFFE); run(20);
        // random mix
        cur_req = "R8";
        for (int k = 0; k < 400; k++) begin
            {evt_a, evt_b, evt_c, evt_d} = 4'($urandom) & 4'($urandom);
            {buf_c_mode, buf_d_mode, sync_clr_in} = 3'($urandom);
            casc_en = (k >= 200); casc_tick = 1'($urandom);
            if (k % 50 == 0) set_ctl(8'($urandom));
            else tick();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule